// File: doc/BRIEF.md
# eMMC PHY Bring-up and Speed-Mode Sequencer

This block is a hardware sequencer that brings an eMMC pad PHY out of power-down and configures it for a bus speed mode. It acts as the master of an 8-bit PHY register port. A single `start` pulse runs a fixed script of register writes and status polls. The script selects the bus width and enables the delay line. It powers up the command, data, strobe and clock pads and runs the IO impedance calibration. It then sets retention, pull-ups and the clock buffer, and loads the tap-delay, DLL-trim and mode values for the requested speed mode.

The sequencer latches the mode, clock-frequency code, drive-strength code and bus-width select when `start` is accepted, so the requesting logic may change them afterwards. Each status poll reads the same register again until the expected bit is set. The poll is bounded by a cycle limit given as a parameter. When the limit runs out, the run ends with a one-cycle `error` pulse and the sequencer returns to idle. A successful run ends with a one-cycle `done` pulse.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `done`, `error` and `reg_req` are low and the sequencer waits for `start`.
- R2: The configuration inputs are captured in the cycle `start` is accepted. Later changes to them, and further `start` pulses during a run, do not change the access sequence.
- R3: With `bus_4bit`=1 the first access writes 0x01 to address 0x24. With `bus_4bit`=0 that write is left out.
- R4: Power-up writes follow next, in this order: 0x00←0x08, 0x01←0x02, 0x20←0x01, 0x21←0xFF, 0x22←0x01, 0x23←0x01.
- R5: Calibration writes 0x01←0x42 and 0x02←0x02. It then reads address 0x03 repeatedly until a read returns bit 4 set, and ignores all other bits of the read data.
- R6: After calibration the sequencer writes 0x06←0x03, 0x08←0x02, 0x07←0xFF, 0x09←0xFF, 0x0F←0x07, 0x11←0x04.
- R7: For HS200 (`mode_sel`=2) and HS400 (4) the next write is 0x01←0x42 | (`drive_code`<<2). The other modes leave it out.
- R8: Next come output tap 0x0D and input tap 0x0C. Legacy (0) writes 0x00/0x00, HS (1) and DDR52 (3) write 0x07/0x05, HS200 writes 0x05/0x00, HS400 writes 0x03/0x15, and enhanced strobe (5) writes 0x03/0x00. Codes 6 and 7 run as legacy.
- R9: Every mode except legacy writes 0x12←0x08. All modes then write 0x00←0x00. Every mode except legacy then writes 0x00←(f<<5)|0x08, where `freq_code` 0,1,2,3 gives f = 0,1,2,0.
- R10: The sequencer then reads 0x00 until bit 4 is set and finally writes the mode register 0x11: legacy 0x04, HS 0x00, HS200 0x00, DDR52 0x08, HS400 0x02, enhanced strobe 0x01.
- R11: Each access holds `reg_req` high, with `reg_wr`, `reg_addr` and `reg_wdata` stable, until `reg_ack` is seen. The next access starts only after that.
- R12: Once a poll step has lasted `POLL_LIMIT` cycles, the next read that misses ends the run. `error` pulses for one cycle, `done` is not raised, and the sequencer goes idle.
- R13: `done` is high for exactly one cycle, two clock edges after the acknowledge of the final write, and no access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode_sel | input | 3 | Speed mode: 0 legacy, 1 HS, 2 HS200, 3 DDR52, 4 HS400, 5 enhanced strobe |
| freq_code | input | 2 | Card clock: 0 200 MHz, 1 100 MHz, 2 50 MHz, 3 other |
| drive_code | input | 3 | Pad drive-strength code |
| bus_4bit | input | 1 | 1 selects a 4-bit data bus |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse on poll timeout |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 write, 0 read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 8 | Write data (zero on reads) |
| reg_ack | input | 1 | One-cycle access complete |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |

## Verification
An access is taken at the first clock edge that sees `reg_ack`. The next request rises one cycle later, so each access takes its acknowledge latency plus two cycles. `done` is visible two falling edges after the falling edge that raised the final acknowledge. `error` is visible at the falling edge after the edge that took a missing read once the poll has lasted `POLL_LIMIT` cycles, which places it between `POLL_LIMIT`-latency and `POLL_LIMIT`+2 cycles after the first poll acknowledge. The bench's register model works on falling edges, so it reads each request and compares it with the expected list half a cycle after it changes. It measures the `done` and `error` delays by counting those same falling edges.

// File: rtl/phy_seq_pkg.sv
// Shared types and register addresses for the PHY bring-up sequencer.
// Assumes an 8-bit address / 8-bit data register port on the PHY.
package phy_seq_pkg;

    // Script length: steps 0..STEP_CNT-1, last one terminates.
    localparam int STEP_CNT = 25;
    localparam int IDX_W    = $clog2(STEP_CNT + 1);
    localparam int RW       = 8;

    // PHY register addresses used by the script.
    localparam logic [RW-1:0] A_DLL      = 8'h00;
    localparam logic [RW-1:0] A_PAD1     = 8'h01;
    localparam logic [RW-1:0] A_PAD2     = 8'h02;
    localparam logic [RW-1:0] A_PADSTS   = 8'h03;
    localparam logic [RW-1:0] A_HOLD_SIG = 8'h06;
    localparam logic [RW-1:0] A_HOLD_DAT = 8'h07;
    localparam logic [RW-1:0] A_PULL_SIG = 8'h08;
    localparam logic [RW-1:0] A_PULL_DAT = 8'h09;
    localparam logic [RW-1:0] A_ITAP     = 8'h0C;
    localparam logic [RW-1:0] A_OTAP     = 8'h0D;
    localparam logic [RW-1:0] A_CLKBUF   = 8'h0F;
    localparam logic [RW-1:0] A_MODE     = 8'h11;
    localparam logic [RW-1:0] A_TRIM     = 8'h12;
    localparam logic [RW-1:0] A_PWR_CMD  = 8'h20;
    localparam logic [RW-1:0] A_PWR_DAT  = 8'h21;
    localparam logic [RW-1:0] A_PWR_STB  = 8'h22;
    localparam logic [RW-1:0] A_PWR_CLK  = 8'h23;
    localparam logic [RW-1:0] A_WIDTH    = 8'h24;

    // Status bit shared by calibration-done and DLL-ready polls.
    localparam logic [RW-1:0] READY_MASK = 8'h10;

    typedef enum logic [1:0] {
        K_SKIP  = 2'd0,
        K_WRITE = 2'd1,
        K_POLL  = 2'd2,
        K_END   = 2'd3
    } step_kind_t;

    // One script step; for polls 'val' is the bit mask to wait on.
    typedef struct packed {
        step_kind_t    kind;
        logic [RW-1:0] addr;
        logic [RW-1:0] val;
    } step_t;

    typedef enum logic [2:0] {
        M_LEGACY = 3'd0,
        M_HS     = 3'd1,
        M_HS200  = 3'd2,
        M_DDR52  = 3'd3,
        M_HS400  = 3'd4,
        M_ESTRB  = 3'd5
    } speed_t;

endpackage

// File: rtl/phy_seq_cfg.sv
// Captures the request configuration at start and decodes the per-mode
// register values. Assumes 'load' is high for one cycle per accepted start.
module phy_seq_cfg
    import phy_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [2:0]    mode_in,
    input  logic [1:0]    freq_in,
    input  logic [2:0]    drv_in,
    input  logic          bus4_in,
    output logic          bus4,
    output logic [2:0]    drv,
    output logic [2:0]    clk_fld,
    output logic          legacy,
    output logic          drv_upd,
    output logic [RW-1:0] otap,
    output logic [RW-1:0] itap,
    output logic [RW-1:0] mode_val
);
    logic [2:0] mode_q;
    logic [1:0] freq_q;
    speed_t     spd;

    // Hold the configuration for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            freq_q <= '0;
            drv    <= '0;
            bus4   <= 1'b0;
        end else if (load) begin
            mode_q <= mode_in;
            freq_q <= freq_in;
            drv    <= drv_in;
            bus4   <= bus4_in;
        end
    end

    // Unused mode codes fall back to legacy; "other" frequency maps to 0.
    always_comb begin
        spd     = (mode_q > 3'd5) ? M_LEGACY : speed_t'(mode_q);
        clk_fld = (freq_q == 2'd3) ? 3'd0 : {1'b0, freq_q};
    end

    // Per-mode tap, mode and optional-write decode.
    always_comb begin
        legacy  = 1'b0;
        drv_upd = 1'b0;
        unique case (spd)
            M_HS:    begin otap = 8'h07; itap = 8'h05; mode_val = 8'h00; end
            M_HS200: begin otap = 8'h05; itap = 8'h00; mode_val = 8'h00; drv_upd = 1'b1; end
            M_DDR52: begin otap = 8'h07; itap = 8'h05; mode_val = 8'h08; end
            M_HS400: begin otap = 8'h03; itap = 8'h15; mode_val = 8'h02; drv_upd = 1'b1; end
            M_ESTRB: begin otap = 8'h03; itap = 8'h00; mode_val = 8'h01; end
            default: begin otap = 8'h00; itap = 8'h00; mode_val = 8'h04; legacy = 1'b1; end
        endcase
    end

endmodule

// File: rtl/phy_seq_script.sv
// Combinational script: maps a step index and the decoded configuration
// to one step (skip, write, poll or end). Assumes idx counts up from 0.
module phy_seq_script
    import phy_seq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             bus4,
    input  logic [2:0]       drv,
    input  logic [2:0]       clk_fld,
    input  logic             legacy,
    input  logic             drv_upd,
    input  logic [RW-1:0]    otap,
    input  logic [RW-1:0]    itap,
    input  logic [RW-1:0]    mode_val,
    output step_t            st
);
    int unsigned n;

    // Step lookup; optional steps turn into skips.
    always_comb begin
        n  = 32'(idx);
        st = '{kind: K_END, addr: '0, val: '0};
        case (n)
            0:  st = bus4 ? '{K_WRITE, A_WIDTH, 8'h01} : '{K_SKIP, A_WIDTH, 8'h00};
            1:  st = '{K_WRITE, A_DLL,      8'h08};
            2:  st = '{K_WRITE, A_PAD1,     8'h02};
            3:  st = '{K_WRITE, A_PWR_CMD,  8'h01};
            4:  st = '{K_WRITE, A_PWR_DAT,  8'hFF};
            5:  st = '{K_WRITE, A_PWR_STB,  8'h01};
            6:  st = '{K_WRITE, A_PWR_CLK,  8'h01};
            7:  st = '{K_WRITE, A_PAD1,     8'h42};
            8:  st = '{K_WRITE, A_PAD2,     8'h02};
            9:  st = '{K_POLL,  A_PADSTS,   READY_MASK};
            10: st = '{K_WRITE, A_HOLD_SIG, 8'h03};
            11: st = '{K_WRITE, A_PULL_SIG, 8'h02};
            12: st = '{K_WRITE, A_HOLD_DAT, 8'hFF};
            13: st = '{K_WRITE, A_PULL_DAT, 8'hFF};
            14: st = '{K_WRITE, A_CLKBUF,   8'h07};
            15: st = '{K_WRITE, A_MODE,     8'h04};
            16: st = drv_upd ? '{K_WRITE, A_PAD1, 8'h42 | {3'b000, drv, 2'b00}}
                             : '{K_SKIP, A_PAD1, 8'h00};
            17: st = '{K_WRITE, A_OTAP, otap};
            18: st = '{K_WRITE, A_ITAP, itap};
            19: st = legacy ? '{K_SKIP, A_TRIM, 8'h00} : '{K_WRITE, A_TRIM, 8'h08};
            20: st = '{K_WRITE, A_DLL, 8'h00};
            21: st = legacy ? '{K_SKIP, A_DLL, 8'h00}
                            : '{K_WRITE, A_DLL, {clk_fld, 5'b01000}};
            22: st = '{K_POLL,  A_DLL,  READY_MASK};
            23: st = '{K_WRITE, A_MODE, mode_val};
            default: st = '{K_END, 8'h00, 8'h00};
        endcase
    end

endmodule

// File: rtl/phy_seq_timer.sv
// Saturating cycle counter bounding a poll step. Assumes 'clr' is raised
// whenever the script advances or the sequencer is idle.
module phy_seq_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count poll cycles, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (inc && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    // R12: once expired the flag persists until the step is cleared.
    p_expired_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        expired && inc && !clr |=> expired);

endmodule

// File: rtl/phy_bringup_seq.sv
// Top of the PHY bring-up sequencer. Walks the script one step at a time,
// issuing each access on the register port and waiting for its
// acknowledge; polls repeat until the status bit is seen or the poll
// timer runs out. Assumes reg_ack is a one-cycle pulse answering reg_req.
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode_sel,
    input  logic [1:0]    freq_code,
    input  logic [2:0]    drive_code,
    input  logic          bus_4bit,
    output logic          done,
    output logic          error,
    output logic          reg_req,
    output logic          reg_wr,
    output logic [RW-1:0] reg_addr,
    output logic [RW-1:0] reg_wdata,
    input  logic          reg_ack,
    input  logic [RW-1:0] reg_rdata
);
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;

    state_t           state;
    logic [IDX_W-1:0] idx;
    step_t            st;
    logic             load, advance, poll_hit, expired;
    logic             bus4, legacy, drv_upd;
    logic [2:0]       drv, clk_fld;
    logic [RW-1:0]    otap, itap, mode_val;

    assign load = (state == S_IDLE) && start;

    phy_seq_cfg i_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mode_in(mode_sel), .freq_in(freq_code), .drv_in(drive_code), .bus4_in(bus_4bit),
        .bus4(bus4), .drv(drv), .clk_fld(clk_fld), .legacy(legacy), .drv_upd(drv_upd),
        .otap(otap), .itap(itap), .mode_val(mode_val)
    );

    phy_seq_script i_script (
        .idx(idx), .bus4(bus4), .drv(drv), .clk_fld(clk_fld), .legacy(legacy),
        .drv_upd(drv_upd), .otap(otap), .itap(itap), .mode_val(mode_val), .st(st)
    );

    phy_seq_timer #(.LIMIT(POLL_LIMIT)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(advance || state == S_IDLE),
        .inc(state != S_IDLE && st.kind == K_POLL),
        .expired(expired)
    );

    // A poll succeeds when any masked status bit is set.
    assign poll_hit = |(reg_rdata & st.val);

    // Script moves on after a skip, a completed write or a successful poll.
    assign advance = (state == S_FETCH && st.kind == K_SKIP) ||
                     (state == S_XFER && reg_ack && (st.kind == K_WRITE || poll_hit));

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    idx   <= '0;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    if (st.kind == K_END) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (st.kind == K_SKIP) begin
                        idx <= idx + 1'b1;
                    end else begin
                        state <= S_XFER;
                    end
                end
                S_XFER: if (reg_ack) begin
                    if (advance) begin
                        idx   <= idx + 1'b1;
                        state <= S_FETCH;
                    end else if (expired) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Port drive follows the current step while a transfer is open.
    assign reg_req   = (state == S_XFER);
    assign reg_wr    = (st.kind == K_WRITE);
    assign reg_addr  = st.addr;
    assign reg_wdata = (st.kind == K_WRITE) ? st.val : '0;

    // R11: request held until acknowledged.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req);

    // R11: access attributes stable while waiting.
    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_wr));

    // R2: captured configuration does not move during a run.
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_IDLE |=> $stable({otap, itap, mode_val, clk_fld, drv, bus4}));

    // R13: done is a single-cycle pulse with no access beside it.
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !reg_req);

    // R12: error only follows an acknowledged read, never with done.
    p_err_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(reg_ack) && !$past(reg_wr));
    p_err_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

endmodule

// File: tb/test_phy_bringup_seq.sv
`timescale 1ns/1ps
module test_phy_bringup_seq;
    localparam int LIM = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode_sel = '0;
    logic [1:0] freq_code = '0;
    logic [2:0] drive_code = '0;
    logic       bus_4bit = 1'b0;
    logic       done, error, reg_req, reg_wr;
    logic [7:0] reg_addr, reg_wdata;
    logic       reg_ack = 1'b0;
    logic [7:0] reg_rdata = '0;

    always #2 clk = ~clk;

    phy_bringup_seq #(.POLL_LIMIT(LIM)) i_phy_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .freq_code(freq_code), .drive_code(drive_code), .bus_4bit(bus_4bit),
        .done(done), .error(error), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata)
    );

    int n_chk = 0, n_bad = 0;

    // Expected access list.
    logic        exp_wr   [64];
    logic [7:0]  exp_addr [64];
    logic [7:0]  exp_data [64];
    string       exp_tag  [64];
    int n_exp;

    // Model / run state.
    int lat, cmiss, dmiss, tmo;
    int n_log, rd03, rd00, wait_cnt, negs;
    int done_cnt, err_cnt, last_ack_neg, done_neg, err_neg, first_poll_neg;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic w, input logic [7:0] a, input logic [7:0] d, input string t);
        exp_wr[n_exp] = w; exp_addr[n_exp] = a; exp_data[n_exp] = d; exp_tag[n_exp] = t;
        n_exp++;
    endtask

    // Build the expected access list from the requirement text.
    task automatic build(input int mode, input int freq, input int drv, input int bus4);
        int m, nt, clkf;
        logic [7:0] ot, it, mv;
        m = (mode > 5) ? 0 : mode;
        n_exp = 0;
        if (bus4 != 0) push(1, 8'h24, 8'h01, "R3");
        push(1, 8'h00, 8'h08, "R4"); push(1, 8'h01, 8'h02, "R4");
        push(1, 8'h20, 8'h01, "R4"); push(1, 8'h21, 8'hFF, "R4");
        push(1, 8'h22, 8'h01, "R4"); push(1, 8'h23, 8'h01, "R4");
        push(1, 8'h01, 8'h42, "R5"); push(1, 8'h02, 8'h02, "R5");
        if (tmo != 0) begin push(0, 8'h03, 8'h00, "R5"); return; end
        for (int k = 0; k <= cmiss; k++) push(0, 8'h03, 8'h00, "R5");
        push(1, 8'h06, 8'h03, "R6"); push(1, 8'h08, 8'h02, "R6");
        push(1, 8'h07, 8'hFF, "R6"); push(1, 8'h09, 8'hFF, "R6");
        push(1, 8'h0F, 8'h07, "R6"); push(1, 8'h11, 8'h04, "R6");
        if (m == 2 || m == 4) push(1, 8'h01, 8'h42 | 8'(drv << 2), "R7");
        nt = (m == 4 || m == 5) ? 1 : (m == 1 || m == 3) ? 3 : (m == 2) ? 2 : 0;
        ot = (m == 0) ? 8'h00 : 8'((nt << 1) | 1);
        it = (m == 1 || m == 3) ? 8'((2 << 1) | 1) : (m == 4) ? 8'((10 << 1) | 1) : 8'h00;
        push(1, 8'h0D, ot, "R8"); push(1, 8'h0C, it, "R8");
        if (m != 0) push(1, 8'h12, 8'h08, "R9");
        push(1, 8'h00, 8'h00, "R9");
        clkf = (freq == 3) ? 0 : freq;
        if (m != 0) push(1, 8'h00, 8'((clkf << 5) | 8), "R9");
        for (int k = 0; k <= dmiss; k++) push(0, 8'h00, 8'h00, "R10");
        case (m)
            1, 2:    mv = 8'h00;
            3:       mv = 8'h08;
            4:       mv = 8'h02;
            5:       mv = 8'h01;
            default: mv = 8'h04;
        endcase
        push(1, 8'h11, mv, "R10");
    endtask

    // Register-port model and observer, all on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            negs++;
            if (done) begin done_cnt++; done_neg = negs; end
            if (error) begin err_cnt++; err_neg = negs; end
            if (reg_ack) begin
                reg_ack = 1'b0;
            end else if (reg_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    reg_ack = 1'b1;
                    last_ack_neg = negs;
                    reg_rdata = 8'h00;
                    if (!reg_wr && reg_addr == 8'h03) begin
                        rd03++;
                        reg_rdata = (rd03 > cmiss) ? 8'h10 : 8'hEF;
                        if (first_poll_neg < 0) first_poll_neg = negs;
                    end
                    if (!reg_wr && reg_addr == 8'h00) begin
                        rd00++;
                        reg_rdata = (rd00 > dmiss) ? 8'h10 : 8'hEF;
                    end
                    if (tmo != 0 && n_log >= n_exp) begin
                        check(!reg_wr && reg_addr == 8'h03, "R12 repeat-poll",
                              {reg_wr, reg_addr}, 8'h03);
                    end else if (n_log < n_exp) begin
                        check(reg_wr == exp_wr[n_log] && reg_addr == exp_addr[n_log] &&
                              (!reg_wr || reg_wdata == exp_data[n_log]),
                              exp_tag[n_log], {reg_wr, reg_addr, reg_wdata},
                              {exp_wr[n_log], exp_addr[n_log], exp_data[n_log]});
                    end else begin
                        check(1'b0, "R13 extra access", {reg_wr, reg_addr}, 0);
                    end
                    n_log++;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic run(input int mode, input int freq, input int drv, input int bus4,
                       input int l, input int cm, input int dm, input int t, input bit restart);
        lat = l; cmiss = cm; dmiss = dm; tmo = t;
        build(mode, freq, drv, bus4);
        n_log = 0; rd03 = 0; rd00 = 0; wait_cnt = 0;
        done_cnt = 0; err_cnt = 0; first_poll_neg = -1;
        @(negedge clk);
        mode_sel = 3'(mode); freq_code = 2'(freq); drive_code = 3'(drv); bus_4bit = bus4[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: scramble the inputs after capture.
        mode_sel = ~mode_sel; freq_code = ~freq_code; drive_code = ~drive_code; bus_4bit = ~bus_4bit;
        for (int c = 0; c < 4000 && done_cnt == 0 && err_cnt == 0; c++) begin
            @(negedge clk);
            start = (restart && c == 15);
        end
        start = 1'b0;
        repeat (8) @(negedge clk);
        if (t == 0) begin
            check(done_cnt == 1, "R13 done count", done_cnt, 1);
            check(err_cnt == 0, "R12 no error", err_cnt, 0);
            check(n_log == n_exp, "R10 access count", n_log, n_exp);
            check(done_neg - last_ack_neg == 2, "R13 done delay", done_neg - last_ack_neg, 2);
        end else begin
            check(err_cnt == 1, "R12 error count", err_cnt, 1);
            check(done_cnt == 0, "R12 no done", done_cnt, 0);
            check(err_neg - first_poll_neg >= LIM - l && err_neg - first_poll_neg <= LIM + 2,
                  "R12 timeout window", err_neg - first_poll_neg, LIM);
        end
        check(!reg_req, "R11 port idle", reg_req, 0);
    endtask

    initial begin
        negs = 0; last_ack_neg = 0; done_neg = 0; err_neg = 0;
        lat = 0; cmiss = 0; dmiss = 0; tmo = 0; n_exp = 0; n_log = 0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(!done && !error && !reg_req, "R1 reset outputs", {done, error, reg_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !error && !reg_req, "R1 idle outputs", {done, error, reg_req}, 0);
        for (int md = 0; md < 8; md++)
            for (int fq = 0; fq < 4; fq++)
                for (int b4 = 0; b4 < 2; b4++)
                    run(md, fq, (md * 3 + fq + b4) % 8, b4, (md + fq) % 3,
                        (fq + b4) % 4, md % 3, 0, (md == 4 && fq == 1));
        // R12: calibration never completes.
        run(2, 0, 5, 1, 0, 10000, 0, 1, 1'b0);
        run(4, 1, 7, 0, 2, 10000, 0, 1, 1'b0);
        // Recovery after a timeout.
        run(4, 2, 6, 1, 1, 2, 2, 0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule